// File: doc/BRIEF.md
# Multi-Device Start Synchronizer

This block decides when a filter datapath begins to run and holds the host-written control words that the datapath uses. A start request that may arrive at any time, with no relation to the sample clock, passes through a flop chain clocked by the sample clock. The block then turns the first clock cycle in which the synchronized request is seen high into a pulse exactly one clock wide. That pulse leaves the block on a port of its own. It can be wired to the synchronous start input of this device and of other devices on the same clock, so that all of them begin on one edge.

The run state is set only by a high-to-low transition on the synchronous start input, sampled on rising clock edges. A small host port carries a chip select, a write strobe (both active low), a 2-bit address and a 16-bit data word. A write completes on the clock edge where the strobe is sampled high after being sampled low in the cycle before, with chip select low. The data lands in one of four control registers. Any completed write also drops the run state, so the datapath must be started again before it runs with the new settings.

Top module: `start_sequencer`

## Requirements
- R1: While reset is applied, and until the first start event after release, `run_o` and `start_pulse_o` are 0 and all four control registers read 0.
- R2: When `start_req_async` goes high and stays high, `start_pulse_o` goes to 1 after the third rising edge and returns to 0 after the next edge, so it is high for exactly one clock period.
- R3: A request held high for many cycles gives only one pulse. A further pulse needs the request to go low for at least three cycles and then high again.
- R4: `run_o` becomes 1 after the rising edge at which `start_in` is sampled 0, if it was sampled 1 at the edge before. It stays 1 while no write completes.
- R5: `start_in` held low, a low-to-high transition of `start_in`, and more falling edges while running have no effect on `run_o`.
- R6: A write completes at a rising edge where `host_wr_n` is sampled 1 and `host_cs_n` is sampled 0, if `host_wr_n` was sampled 0 at the previous edge. Then register `host_addr` takes `host_data`, and it reads in `ctrl_regs_o[host_addr*16 +: 16]` after that edge.
- R7: A strobe pulse given with `host_cs_n` high changes no register and leaves `run_o` unchanged.
- R8: A completed write changes only the addressed register. The other three keep their values.
- R9: A completed write clears `run_o` at that same edge. If a falling edge of `start_in` is sampled at the same edge, the write wins and `run_o` is 0. A later falling edge starts the block again.
- R10: Holding `host_wr_n` low with `host_cs_n` low writes nothing; only the low-to-high transition of the strobe loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req_async | input | 1 | Start request with no timing relation to clk |
| start_pulse_o | output | 1 | One-cycle pulse derived from the synchronized request |
| start_in | input | 1 | Synchronous start; its falling edge sets the run state |
| run_o | output | 1 | Run state for the datapath |
| host_cs_n | input | 1 | Host chip select, active low |
| host_wr_n | input | 1 | Host write strobe, active low, loads on its rising edge |
| host_addr | input | 2 | Control register select |
| host_data | input | 16 | Host write data |
| ctrl_regs_o | output | 64 | Control register contents, register k in bits k*16+15..k*16 |

## Verification
The two functions that can meet on one edge are a completed host write and a falling edge of the synchronous start input. Both of them act on the run state. The bench provokes this with the strobe going high and `start_in` going low on the same clock edge, and it expects `run_o` to be 0 after that edge, with the written register already updated. It then gives a lone falling edge and expects the run state to return. This shows that the write only took priority for that cycle and did not block later starts.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;

  localparam int unsigned SS_MIN_SYNC = 2;

endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/ss_req_pulse.sv
module ss_req_pulse #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_q_n,
  input  logic req_async,
  output logic pulse_o
);

  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;
  logic              pulse_q;
  logic              pulse_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb sync_d[g] = req_async;
      end else begin : g_next
        always_comb sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_comb begin
    last_d  = sync_q[TOP];
    pulse_d = sync_q[TOP] & ~last_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sync_q  <= '0;
      last_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      last_q  <= last_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/ss_run_ctrl.sv
module ss_run_ctrl
  import ss_pkg::*;
(
  input  logic clk,
  input  logic rst_q_n,
  input  logic start_in,
  input  logic clear_i,
  output logic run_o
);

  run_state_e state_q;
  run_state_e state_d;
  logic       prev_q;
  logic       prev_d;
  logic       fall;

  always_comb begin
    prev_d  = start_in;
    fall    = prev_q & ~start_in;
    state_d = state_q;
    if (clear_i) begin
      state_d = RUN_IDLE;
    end else if (fall) begin
      state_d = RUN_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      prev_q  <= 1'b0;
      state_q <= RUN_IDLE;
    end else begin
      prev_q  <= prev_d;
      state_q <= state_d;
    end
  end

  assign run_o = (state_q == RUN_ACTIVE);

endmodule

// File: rtl/ss_host_regs.sv
module ss_host_regs #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_q_n,
  input  logic                          cs_n,
  input  logic                          wr_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             data,
  output logic                          wr_evt_o,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o
);

  localparam int unsigned NUM_REGS = 1 << ADDR_W;

  logic wr_prev_q;
  logic wr_prev_d;
  logic wr_fire;

  always_comb begin
    wr_prev_d = wr_n;
    wr_fire   = ~cs_n & ~wr_prev_q & wr_n;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wr_prev_q <= 1'b1;
    end else begin
      wr_prev_q <= wr_prev_d;
    end
  end

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic              load_en;
      logic [DATA_W-1:0] word_q;
      logic [DATA_W-1:0] word_d;

      always_comb begin
        load_en = wr_fire & (addr == ADDR_W'(r));
        word_d  = load_en ? data : word_q;
      end

      always_ff @(posedge clk or negedge rst_q_n) begin
        if (!rst_q_n) begin
          word_q <= '0;
        end else begin
          word_q <= word_d;
        end
      end

      assign regs_o[r*DATA_W +: DATA_W] = word_q;
    end
  endgenerate

  assign wr_evt_o = wr_fire;

endmodule

// File: rtl/start_sequencer.sv
module start_sequencer #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_req_async,
  output logic                          start_pulse_o,
  input  logic                          start_in,
  output logic                          run_o,
  input  logic                          host_cs_n,
  input  logic                          host_wr_n,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [DATA_W-1:0]             host_data,
  output logic [(1<<ADDR_W)*DATA_W-1:0] ctrl_regs_o
);

  localparam int unsigned SYNC_USED =
    (SYNC_STAGES < ss_pkg::SS_MIN_SYNC) ? ss_pkg::SS_MIN_SYNC : SYNC_STAGES;
  localparam int unsigned RST_USED =
    (RST_STAGES < ss_pkg::SS_MIN_SYNC) ? ss_pkg::SS_MIN_SYNC : RST_STAGES;

  logic rst_q_n;
  logic wr_evt;

  ss_rst_sync #(.STAGES(RST_USED)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ss_req_pulse #(.STAGES(SYNC_USED)) u_req (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .req_async (start_req_async),
    .pulse_o   (start_pulse_o)
  );

  ss_host_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .cs_n     (host_cs_n),
    .wr_n     (host_wr_n),
    .addr     (host_addr),
    .data     (host_data),
    .wr_evt_o (wr_evt),
    .regs_o   (ctrl_regs_o)
  );

  ss_run_ctrl u_run (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .start_in (start_in),
    .clear_i  (wr_evt),
    .run_o    (run_o)
  );

endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
  parameter int unsigned REGS_W = 64
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              start_in,
  input logic              host_cs_n,
  input logic              host_wr_n,
  input logic              run_o,
  input logic              start_pulse_o,
  input logic [REGS_W-1:0] ctrl_regs_o
);

  logic start_seen_q;
  logic strobe_seen_q;
  logic host_write;
  logic start_fall;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      start_seen_q  <= 1'b0;
      strobe_seen_q <= 1'b1;
    end else begin
      start_seen_q  <= start_in;
      strobe_seen_q <= host_wr_n;
    end
  end

  assign host_write = !host_cs_n && host_wr_n && !strobe_seen_q;
  assign start_fall = start_seen_q && !start_in;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_pulse_o |=> !start_pulse_o); // R2

  AST_RUN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_fall && !host_write) |=> run_o); // R4

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (run_o && !host_write) |=> run_o); // R5

  AST_NO_SPURIOUS_RUN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!run_o && !start_fall) |=> !run_o); // R5

  AST_WRITE_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_q_n)
    host_write |=> !run_o); // R9

  AST_REGS_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    !host_write |=> $stable(ctrl_regs_o)); // R7

endmodule

bind start_sequencer ss_checker #(.REGS_W((1<<ADDR_W)*DATA_W)) u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .start_in      (start_in),
  .host_cs_n     (host_cs_n),
  .host_wr_n     (host_wr_n),
  .run_o         (run_o),
  .start_pulse_o (start_pulse_o),
  .ctrl_regs_o   (ctrl_regs_o)
);

// File: tb/start_sequencer_test.sv
module start_sequencer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start_req_async;
  logic        start_pulse_o;
  logic        start_in;
  logic        run_o;
  logic        host_cs_n;
  logic        host_wr_n;
  logic [1:0]  host_addr;
  logic [15:0] host_data;
  logic [63:0] ctrl_regs_o;

  int unsigned n_checks;
  int unsigned n_fails;
  logic [15:0] exp_reg [4];
  bit          finished;

  start_sequencer uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_req_async (start_req_async),
    .start_pulse_o   (start_pulse_o),
    .start_in        (start_in),
    .run_o           (run_o),
    .host_cs_n       (host_cs_n),
    .host_wr_n       (host_wr_n),
    .host_addr       (host_addr),
    .host_data       (host_data),
    .ctrl_regs_o     (ctrl_regs_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int k = 0; k < 4; k++) check(ctrl_regs_o[k*16 +: 16], exp_reg[k], tag);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_cs_n = 1'b0; host_addr = a; host_data = d; host_wr_n = 1'b0;
    @(negedge clk);
    host_wr_n = 1'b1;
    @(negedge clk);
    host_cs_n = 1'b1;
    exp_reg[a] = d;
  endtask

  task automatic fall_start();
    @(negedge clk); start_in = 1'b1;
    @(negedge clk); start_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_req_async = 1'b0; start_in = 1'b0;
    host_cs_n = 1'b1; host_wr_n = 1'b1; host_addr = '0; host_data = '0;
    for (int k = 0; k < 4; k++) exp_reg[k] = '0;
    repeat (3) @(negedge clk);
    check({15'd0, run_o}, 16'd0, "R1 run in reset");
    check({15'd0, start_pulse_o}, 16'd0, "R1 pulse in reset");
    check_regs("R1 regs in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({15'd0, run_o}, 16'd0, "R1 run after release");
    check_regs("R1 regs after release");
  endtask

  task automatic t_pulse();
    int highs;
    start_req_async = 1'b1;
    @(negedge clk); check({15'd0, start_pulse_o}, 16'd0, "R2 pulse after edge 1");
    @(negedge clk); check({15'd0, start_pulse_o}, 16'd0, "R2 pulse after edge 2");
    @(negedge clk); check({15'd0, start_pulse_o}, 16'd1, "R2 pulse after edge 3");
    @(negedge clk); check({15'd0, start_pulse_o}, 16'd0, "R2 pulse after edge 4");
    highs = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (start_pulse_o) highs++;
    end
    check(16'(highs), 16'd0, "R3 long request single pulse");
    start_req_async = 1'b0;
    repeat (4) @(negedge clk);
    start_req_async = 1'b1;
    highs = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (start_pulse_o) highs++;
    end
    check(16'(highs), 16'd1, "R3 second request second pulse");
    start_req_async = 1'b0;
    repeat (4) @(negedge clk);
    check({15'd0, run_o}, 16'd0, "R5 pulse alone does not run");
  endtask

  task automatic t_run();
    start_in = 1'b0;
    repeat (3) @(negedge clk);
    check({15'd0, run_o}, 16'd0, "R5 held low no run");
    start_in = 1'b1;
    @(negedge clk);
    check({15'd0, run_o}, 16'd0, "R5 rising edge no run");
    start_in = 1'b0;
    @(negedge clk);
    check({15'd0, run_o}, 16'd1, "R4 falling edge sets run");
    repeat (5) @(negedge clk);
    check({15'd0, run_o}, 16'd1, "R4 run holds");
    fall_start();
    check({15'd0, run_o}, 16'd1, "R5 extra fall keeps run");
  endtask

  task automatic t_write();
    host_write(2'd2, 16'hA5C3);
    check_regs("R6 write reg 2");
    check({15'd0, run_o}, 16'd0, "R9 write clears run");
    host_write(2'd0, 16'h1234);
    host_write(2'd3, 16'hFFFF);
    host_write(2'd1, 16'h0F0F);
    check_regs("R8 other regs kept");
    fall_start();
    check({15'd0, run_o}, 16'd1, "R9 restart after write");
  endtask

  task automatic t_ignored();
    @(negedge clk);
    host_cs_n = 1'b1; host_addr = 2'd1; host_data = 16'hDEAD; host_wr_n = 1'b0;
    @(negedge clk); host_wr_n = 1'b1;
    @(negedge clk);
    check_regs("R7 deselected write ignored");
    check({15'd0, run_o}, 16'd1, "R7 run kept");
    host_cs_n = 1'b0; host_addr = 2'd3; host_data = 16'hBEEF; host_wr_n = 1'b0;
    repeat (5) @(negedge clk);
    check_regs("R10 held strobe no load");
    check({15'd0, run_o}, 16'd1, "R10 held strobe run kept");
    host_wr_n = 1'b1;
    @(negedge clk);
    host_cs_n = 1'b1;
    exp_reg[3] = 16'hBEEF;
    check_regs("R10 strobe release loads");
    check({15'd0, run_o}, 16'd0, "R9 release clears run");
  endtask

  task automatic t_collide();
    fall_start();
    check({15'd0, run_o}, 16'd1, "R4 run before collision");
    @(negedge clk);
    start_in = 1'b1; host_cs_n = 1'b0; host_addr = 2'd0; host_data = 16'h7E81; host_wr_n = 1'b0;
    @(negedge clk);
    start_in = 1'b0; host_wr_n = 1'b1;
    @(negedge clk);
    host_cs_n = 1'b1;
    exp_reg[0] = 16'h7E81;
    check({15'd0, run_o}, 16'd0, "R9 write wins over fall");
    check_regs("R9 write lands in collision");
    fall_start();
    check({15'd0, run_o}, 16'd1, "R9 later fall restarts");
  endtask

  initial begin
    n_checks = 0; n_fails = 0; finished = 1'b0;
    t_reset();
    t_pulse();
    t_run();
    t_write();
    t_ignored();
    t_collide();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule